// File: doc/BRIEF.md
# RDS Data-Available and Sync-Loss Flag Logic

This block sits beside an RDS block decoder and turns its per-block strobes into two host-visible flags: a data-available flag and a sync-loss flag. It follows the decoder through three states: searching for synchronization, synchronized, and idle. The state decides which block events set the data-available flag. The rule also depends on a two-bit mode select. Mode A and mode B set the flag on every block once synchronized. Mode C sets it on every second block. Mode B also sets it early during search, on a single valid A or C' block, so the host can compare the programme identification quickly.

When the flywheel reports lost synchronization, the sync-loss mask picks the reaction. With the mask at 0, the block raises the data-available flag and restarts the search. With the mask at 1, it raises the sync-loss flag and an interrupt request, and parks the decoder in idle until the host requests a new search. A host read of either of two designated data-byte addresses clears the data-available flag. Interrupt requests go out as single-cycle pulses to an external interrupt controller.

Top module: `rds_flag_ctrl`

## Requirements
- R1: After reset both flags are 0, both interrupt pulses are 0, and the decoder state is search (dec_idle = 0, dec_synced = 0).
- R2: In search, in any mode, a block strobe that is valid and in correct sequence sets the data-available flag on the next edge, but only if bad_cnt < bad_lim. With bad_cnt >= bad_lim it does not set the flag.
- R3: In search with mode = 01 (B), a valid block strobe marked A/C' sets the data-available flag even without correct sequence. In mode 00 (A) the same strobe does not set it.
- R4: When synchronized in mode 00 (A), 01 (B) or 11 (treated as A), every block strobe sets the data-available flag.
- R5: When synchronized in mode 10 (C), the flag sets on every second block strobe. The first strobe after entering synchronization never sets it, and the second one does.
- R6: When synchronized with lsync_mask = 0, sync_lost sets the data-available flag and returns the state to search.
- R7: When synchronized with lsync_mask = 1, sync_lost sets the sync-loss flag, gives a one-cycle irq_lsync pulse and moves to idle. The data-available flag is unchanged.
- R8: In idle, block strobes and sync_acq have no effect. new_sync_req clears the sync-loss flag and moves to search.
- R9: host_rd at address 0x0F or 0x11 clears the data-available flag. A read at any other address leaves it unchanged.
- R10: If a set condition and a clearing read occur in the same cycle, the data-available flag ends up set.
- R11: Each setting of the data-available flag gives a one-cycle irq_dav pulse, in the cycle the flag shows the set, when dav_mask = 1. No pulse is given when dav_mask = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Flag mode: 00 A, 01 B, 10 C, 11 as A |
| dav_mask | input | 1 | Enables irq_dav |
| lsync_mask | input | 1 | Selects the sync-loss reaction |
| bad_cnt | input | CNT_W | Bad-block count from the decoder |
| bad_lim | input | CNT_W | Bad-block limit |
| blk_strobe | input | 1 | One block processed this cycle |
| blk_valid | input | 1 | The block passed checking |
| blk_is_ac | input | 1 | The block is of type A or C' |
| blk_seq_ok | input | 1 | The block follows a valid block in correct sequence |
| sync_acq | input | 1 | The decoder reports synchronization reached |
| sync_lost | input | 1 | The flywheel reports synchronization lost |
| new_sync_req | input | 1 | Host request to start a new search |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | ADDR_W | Host read byte address |
| dav_flag | output | 1 | Data-available flag |
| lsync_flag | output | 1 | Sync-loss flag |
| dec_idle | output | 1 | Decoder is idle |
| dec_synced | output | 1 | Decoder is synchronized |
| irq_dav | output | 1 | Data-available interrupt pulse |
| irq_lsync | output | 1 | Sync-loss interrupt pulse |

## Verification
The bench enters synchronization in mode C and checks that only the second strobe sets the flag. A pair counter that kept its phase across a sync loss would set the flag one block too early. It places a strobe and a clearing read in the same cycle, because a clear-first design would drop that block's notice. It also tests a bad-block count equal to the limit, where an off-by-one compare would flag a block that should stay silent. It drives block strobes into the idle state, where a design that failed to park would raise flags the host never asked for.

// File: rtl/rds_flag_pkg.sv
package rds_flag_pkg;
   typedef enum logic [1:0] {
      ST_SEARCH = 2'd0,
      ST_SYNCED = 2'd1,
      ST_IDLE   = 2'd2
   } dec_state_e;

   typedef enum logic [1:0] {
      MODE_A = 2'd0,
      MODE_B = 2'd1,
      MODE_C = 2'd2
   } flag_mode_e;

   function automatic flag_mode_e norm_mode(input logic [1:0] m);
      case (m)
         2'd1:    norm_mode = MODE_B;
         2'd2:    norm_mode = MODE_C;
         default: norm_mode = MODE_A;
      endcase
   endfunction
endpackage

// File: rtl/rds_sync_fsm.sv
module rds_sync_fsm
   import rds_flag_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sync_acq,
   input  logic       sync_lost,
   input  logic       lsync_mask,
   input  logic       new_sync_req,
   output dec_state_e state,
   output logic       lsync_set,
   output logic       lsync_clr
);
   dec_state_e state_nxt;

   always_comb begin
      state_nxt = state;
      case (state)
         ST_SEARCH: if (sync_acq) state_nxt = ST_SYNCED;
         ST_SYNCED: if (sync_lost) state_nxt = lsync_mask ? ST_IDLE : ST_SEARCH;
         ST_IDLE:   if (new_sync_req) state_nxt = ST_SEARCH;
         default:   state_nxt = ST_SEARCH;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_SEARCH;
      else        state <= state_nxt;
   end

   assign lsync_set = (state == ST_SYNCED) && sync_lost && lsync_mask;
   assign lsync_clr = (state == ST_IDLE) && new_sync_req;

   p_loss_search_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SYNCED && sync_lost && !lsync_mask) |=> (state == ST_SEARCH));
   p_loss_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SYNCED && sync_lost && lsync_mask) |=> (state == ST_IDLE));
   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && !new_sync_req) |=> (state == ST_IDLE));
endmodule

// File: rtl/rds_dav_cond.sv
module rds_dav_cond
   import rds_flag_pkg::*;
#(
   parameter int CNT_W    = 5,
   parameter int PAIR_LEN = 2
)(
   input  logic             clk,
   input  logic             rst_n,
   input  dec_state_e       state,
   input  logic [1:0]       mode,
   input  logic [CNT_W-1:0] bad_cnt,
   input  logic [CNT_W-1:0] bad_lim,
   input  logic             blk_strobe,
   input  logic             blk_valid,
   input  logic             blk_is_ac,
   input  logic             blk_seq_ok,
   input  logic             sync_lost,
   input  logic             lsync_mask,
   output logic             dav_set
);
   localparam int PAIR_W = (PAIR_LEN > 1) ? $clog2(PAIR_LEN) : 1;

   initial begin : elab_chk
      assert (CNT_W >= 1) else $error("CNT_W must be at least 1");
      assert (PAIR_LEN >= 1) else $error("PAIR_LEN must be at least 1");
   end

   flag_mode_e mode_n;
   logic       search_set, synced_set, loss_set, sync_blk, pair_done;

   assign mode_n   = norm_mode(mode);
   assign sync_blk = (state == ST_SYNCED) && blk_strobe;

   assign search_set = (state == ST_SEARCH) && blk_strobe && blk_valid &&
                       ((blk_seq_ok && (bad_cnt < bad_lim)) ||
                        (mode_n == MODE_B && blk_is_ac));

   generate
      if (PAIR_LEN == 1) begin : g_single
         assign pair_done = 1'b1;
      end else begin : g_pair
         logic [PAIR_W-1:0] pair_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pair_cnt <= '0;
            else if (state != ST_SYNCED)
               pair_cnt <= '0;
            else if (sync_blk && mode_n == MODE_C)
               pair_cnt <= (pair_cnt == PAIR_W'(PAIR_LEN - 1)) ? '0 : pair_cnt + 1'b1;
         end
         assign pair_done = (pair_cnt == PAIR_W'(PAIR_LEN - 1));

         p_pair_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (state == ST_SYNCED && $past(state) != ST_SYNCED &&
             mode_n == MODE_C && blk_strobe && !sync_lost) |-> !dav_set);
      end
   endgenerate

   assign synced_set = sync_blk && ((mode_n != MODE_C) || pair_done);
   assign loss_set   = (state == ST_SYNCED) && sync_lost && !lsync_mask;
   assign dav_set    = search_set || synced_set || loss_set;

   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !dav_set);
   p_limit_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SEARCH && mode_n == MODE_A && bad_cnt >= bad_lim) |-> !dav_set);
endmodule

// File: rtl/rds_flag_bits.sv
module rds_flag_bits #(
   parameter int              ADDR_W  = 5,
   parameter logic [ADDR_W-1:0] RD_A  = 5'h0F,
   parameter logic [ADDR_W-1:0] RD_B  = 5'h11,
   parameter bit              REG_IRQ = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dav_set,
   input  logic              lsync_set,
   input  logic              lsync_clr,
   input  logic              dav_mask,
   input  logic              host_rd,
   input  logic [ADDR_W-1:0] host_addr,
   output logic              dav_flag,
   output logic              lsync_flag,
   output logic              irq_dav,
   output logic              irq_lsync
);
   initial begin : elab_chk
      assert (RD_A != RD_B) else $error("clearing addresses must differ");
   end

   logic rd_hit;
   assign rd_hit = host_rd && ((host_addr == RD_A) || (host_addr == RD_B));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dav_flag   <= 1'b0;
         lsync_flag <= 1'b0;
      end else begin
         if (dav_set)     dav_flag <= 1'b1;
         else if (rd_hit) dav_flag <= 1'b0;
         if (lsync_set)      lsync_flag <= 1'b1;
         else if (lsync_clr) lsync_flag <= 1'b0;
      end
   end

   generate
      if (REG_IRQ) begin : g_reg_irq
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               irq_dav   <= 1'b0;
               irq_lsync <= 1'b0;
            end else begin
               irq_dav   <= dav_set && dav_mask;
               irq_lsync <= lsync_set;
            end
         end
         p_irq_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
            irq_dav |-> dav_flag);
         p_irq_lsync_r7: assert property (@(posedge clk) disable iff (!rst_n)
            irq_lsync |-> lsync_flag);
      end else begin : g_comb_irq
         assign irq_dav   = dav_set && dav_mask;
         assign irq_lsync = lsync_set;
      end
   endgenerate

   p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      dav_set |=> dav_flag);
   p_read_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && !dav_set) |=> !dav_flag);
endmodule

// File: rtl/rds_flag_ctrl.sv
module rds_flag_ctrl
   import rds_flag_pkg::*;
#(
   parameter int                CNT_W    = 5,
   parameter int                ADDR_W   = 5,
   parameter logic [ADDR_W-1:0] RD_A     = 5'h0F,
   parameter logic [ADDR_W-1:0] RD_B     = 5'h11,
   parameter int                PAIR_LEN = 2,
   parameter bit                REG_IRQ  = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode,
   input  logic              dav_mask,
   input  logic              lsync_mask,
   input  logic [CNT_W-1:0]  bad_cnt,
   input  logic [CNT_W-1:0]  bad_lim,
   input  logic              blk_strobe,
   input  logic              blk_valid,
   input  logic              blk_is_ac,
   input  logic              blk_seq_ok,
   input  logic              sync_acq,
   input  logic              sync_lost,
   input  logic              new_sync_req,
   input  logic              host_rd,
   input  logic [ADDR_W-1:0] host_addr,
   output logic              dav_flag,
   output logic              lsync_flag,
   output logic              dec_idle,
   output logic              dec_synced,
   output logic              irq_dav,
   output logic              irq_lsync
);
   dec_state_e state;
   logic       dav_set, lsync_set, lsync_clr;

   rds_sync_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .sync_acq(sync_acq), .sync_lost(sync_lost),
      .lsync_mask(lsync_mask), .new_sync_req(new_sync_req), .state(state),
      .lsync_set(lsync_set), .lsync_clr(lsync_clr)
   );

   rds_dav_cond #(.CNT_W(CNT_W), .PAIR_LEN(PAIR_LEN)) u_cond (
      .clk(clk), .rst_n(rst_n), .state(state), .mode(mode),
      .bad_cnt(bad_cnt), .bad_lim(bad_lim), .blk_strobe(blk_strobe),
      .blk_valid(blk_valid), .blk_is_ac(blk_is_ac), .blk_seq_ok(blk_seq_ok),
      .sync_lost(sync_lost), .lsync_mask(lsync_mask), .dav_set(dav_set)
   );

   rds_flag_bits #(.ADDR_W(ADDR_W), .RD_A(RD_A), .RD_B(RD_B), .REG_IRQ(REG_IRQ)) u_bits (
      .clk(clk), .rst_n(rst_n), .dav_set(dav_set), .lsync_set(lsync_set),
      .lsync_clr(lsync_clr), .dav_mask(dav_mask), .host_rd(host_rd),
      .host_addr(host_addr), .dav_flag(dav_flag), .lsync_flag(lsync_flag),
      .irq_dav(irq_dav), .irq_lsync(irq_lsync)
   );

   assign dec_idle   = (state == ST_IDLE);
   assign dec_synced = (state == ST_SYNCED);
endmodule

// File: tb/test_rds_flag_ctrl.sv
module test_rds_flag_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode = 2'd0;
   logic       dav_mask = 1'b1, lsync_mask = 1'b0;
   logic [4:0] bad_cnt = 5'd0, bad_lim = 5'd8;
   logic       blk_strobe = 0, blk_valid = 0, blk_is_ac = 0, blk_seq_ok = 0;
   logic       sync_acq = 0, sync_lost = 0, new_sync_req = 0, host_rd = 0;
   logic [4:0] host_addr = 5'd0;
   logic       dav_flag, lsync_flag, dec_idle, dec_synced, irq_dav, irq_lsync;

   always #10 clk = ~clk;

   rds_flag_ctrl i_rds_flag_ctrl (
      .clk(clk), .rst_n(rst_n), .mode(mode), .dav_mask(dav_mask),
      .lsync_mask(lsync_mask), .bad_cnt(bad_cnt), .bad_lim(bad_lim),
      .blk_strobe(blk_strobe), .blk_valid(blk_valid), .blk_is_ac(blk_is_ac),
      .blk_seq_ok(blk_seq_ok), .sync_acq(sync_acq), .sync_lost(sync_lost),
      .new_sync_req(new_sync_req), .host_rd(host_rd), .host_addr(host_addr),
      .dav_flag(dav_flag), .lsync_flag(lsync_flag), .dec_idle(dec_idle),
      .dec_synced(dec_synced), .irq_dav(irq_dav), .irq_lsync(irq_lsync)
   );

   typedef struct {
      logic [5:0] v;
      string      tag;
   } exp_t;
   exp_t q[$];

   int checks = 0, fails = 0;
   bit finished = 0;

   // bench reference model: 0 search, 1 synced, 2 idle
   int   m_st = 0;
   bit   m_pair = 0;
   logic m_dav = 0, m_ls = 0;

   task automatic step(input string tag);
      bit set = 0, lset = 0, irqd;
      int nst = m_st;
      int mn = (mode == 2'd3) ? 0 : int'(mode);
      exp_t e;
      case (m_st)
         0: begin
            if (blk_strobe && blk_valid && blk_seq_ok && bad_cnt < bad_lim) set = 1;
            if (mn == 1 && blk_strobe && blk_valid && blk_is_ac) set = 1;
            if (sync_acq) begin nst = 1; m_pair = 0; end
         end
         1: begin
            if (blk_strobe) begin
               if (mn == 2) begin
                  if (m_pair) set = 1;
                  m_pair = ~m_pair;
               end else set = 1;
            end
            if (sync_lost) begin
               if (!lsync_mask) begin set = 1; nst = 0; end
               else begin lset = 1; nst = 2; end
            end
         end
         default: if (new_sync_req) begin nst = 0; m_ls = 0; end
      endcase
      if (set) m_dav = 1;
      else if (host_rd && (host_addr == 5'h0F || host_addr == 5'h11)) m_dav = 0;
      if (lset) m_ls = 1;
      irqd = set && dav_mask;
      if (nst != 1) m_pair = 0;
      m_st = nst;
      e.v = {m_dav, m_ls, (m_st == 2), (m_st == 1), irqd, lset};
      e.tag = tag;
      q.push_back(e);
      @(posedge clk);
      @(negedge clk);
      blk_strobe = 0; blk_valid = 0; blk_is_ac = 0; blk_seq_ok = 0;
      sync_acq = 0; sync_lost = 0; new_sync_req = 0; host_rd = 0;
   endtask

   // monitor: compare outputs after each edge
   always @(posedge clk) begin
      #2;
      if (q.size() > 0) begin
         exp_t e;
         logic [5:0] act;
         e = q.pop_front();
         act = {dav_flag, lsync_flag, dec_idle, dec_synced, irq_dav, irq_lsync};
         checks++;
         if (act !== e.v) begin
            fails++;
            $display("FAIL %s: {dav,lsync,idle,synced,irq_dav,irq_lsync} actual %b expected %b",
                     e.tag, act, e.v);
         end
      end
   end

   task automatic blk(input bit v, input bit ac, input bit sq);
      blk_strobe = 1; blk_valid = v; blk_is_ac = ac; blk_seq_ok = sq;
   endtask

   task automatic rd(input logic [4:0] a);
      host_rd = 1; host_addr = a;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      step("R1");                                  // reset state
      blk(1, 0, 1); bad_cnt = 5'd3; step("R2");    // set in search, irq
      rd(5'h0F); step("R9");                       // clear via first address
      blk(1, 0, 1); bad_cnt = 5'd8; step("R2");    // count == limit: no set
      blk(1, 0, 1); bad_cnt = 5'd7; step("R2");    // set again
      rd(5'h10); step("R9");                       // other address: no effect
      rd(5'h11); step("R9");                       // second address clears
      blk(1, 1, 0); step("R3");                    // mode A: A/C' alone no set
      mode = 2'd1; blk(1, 1, 0); step("R3");       // mode B: early set
      rd(5'h0F); step("R9");
      mode = 2'd0; sync_acq = 1; step("R4");       // enter sync
      blk(1, 0, 0); step("R4");
      blk(1, 0, 0); rd(5'h11); step("R10");        // set wins over read
      rd(5'h11); step("R9");
      mode = 2'd3; blk(1, 0, 0); step("R4");       // 11 treated as A
      rd(5'h0F); step("R9");
      mode = 2'd1; blk(0, 0, 0); step("R4");
      sync_lost = 1; rd(5'h0F); step("R6");        // loss with mask 0
      rd(5'h0F); step("R9");
      mode = 2'd2; sync_acq = 1; step("R5");
      blk(1, 0, 0); step("R5");                    // first after sync: no set
      blk(1, 0, 0); step("R5");                    // second: set
      rd(5'h0F); step("R9");
      blk(1, 0, 0); step("R5");
      blk(1, 0, 0); step("R5");
      rd(5'h11); step("R9");
      dav_mask = 0; mode = 2'd0; blk(1, 0, 0); step("R11"); // no irq
      dav_mask = 1; lsync_mask = 1; sync_lost = 1; step("R7");
      step("R7");                                  // pulse is single-cycle
      mode = 2'd1; blk(1, 1, 1); bad_cnt = 5'd0; sync_acq = 1; step("R8");
      rd(5'h0F); step("R8");
      blk(1, 0, 1); step("R8");
      new_sync_req = 1; step("R8");                // back to search, flag clear
      blk(1, 0, 1); step("R2");
      step("R11");
      @(negedge clk);
      finished = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end
endmodule